// File: doc/BRIEF.md
# Serial Wire Debug Packet Master

This block is the host end of a two-wire debug link. It runs one complete packet at a time. Each packet opens with an 8-bit request and then either writes or reads one 32-bit word. The block produces the serial clock from the system clock through a programmable half-period divider. It drives the bidirectional data line through three separate signals: an output value, an output enable and a sampled input.

A caller gives one command: access-port or debug-port select, read or write, a 2-bit register address and the write word. The engine then builds the request with its parity and frees the line for each turnaround. It collects the 3-bit acknowledge from the target. On an OK acknowledge it moves the data word and its parity in the direction the command asks for. When the packet is done it pads the bus with zero cycles and gives back the acknowledge, the read word and the error flags. Retrying after WAIT, line resets and any meaning of the registers belong to the logic that sits above this block.

Top module: `swdm_master`

## Requirements
- R1: After reset the serial clock is low, the data output enable is low, `cmd_ready` is high and `rsp_valid` is low.
- R2: A request is 8 slots sent in this order: 1, select, read flag, address bit 0, address bit 1, parity, 0, 1. The parity is 1 when the four middle fields hold an odd number of ones.
- R3: The clock holds each level for `cfg_half`+1 system clocks, so a full period is 2*(`cfg_half`+1). The clock stays low while no packet is in progress.
- R4: The host releases the line (output enable low) for the turnaround slot right after the request and for all three acknowledge slots. The acknowledge is sampled least significant bit first: OK=001, WAIT=010, FAULT=100.
- R5: A write that gets OK releases the line for one turnaround slot. It then drives 32 data slots, least significant bit first, and one parity slot that is 1 when the word holds an odd number of ones.
- R6: A read that gets OK samples 32 data slots, least significant bit first, and then one parity slot. `rsp_par_err` is set when the sampled parity does not match odd parity over the word. One released turnaround slot follows.
- R7: On WAIT or FAULT there is no data phase. One released turnaround slot follows, then the idle padding, and the code is reported in `rsp_ack`. The packet takes 21 clock periods.
- R8: Any other acknowledge sets `rsp_proto_err` and returns the code as it was sampled. The line stays released and no padding is sent, so the packet takes 13 clock periods.
- R9: Every packet with a legal acknowledge ends with IDLE_CYC (8) slots in which the host drives 0. OK packets take 54 clock periods in total.
- R10: The host changes its data output and output enable only when the clock falls. While the clock is high both stay constant, and target data is sampled as the clock rises.
- R11: `rsp_valid` pulses for one system clock when the final slot ends, and `cmd_ready` is high in that same cycle. A command presented in that cycle starts at once, and the response fields keep their values until the next packet completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half | input | DIV_W | Half-period of the serial clock, minus one, in system clocks |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine free; command taken on this edge if valid |
| cmd_ap | input | 1 | 1 selects an access-port register, 0 a debug-port register |
| cmd_rnw | input | 1 | 1 for a read, 0 for a write |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | DATA_W | Word to write |
| swclk | output | 1 | Serial clock to the target |
| swdio_o | output | 1 | Data value driven by the host |
| swdio_oe | output | 1 | Host drives the data line when high |
| swdio_i | input | 1 | Data line as seen at the host |
| rsp_valid | output | 1 | One-cycle pulse when a packet ends |
| rsp_ack | output | 3 | Acknowledge as sampled, bit 0 first on the wire |
| rsp_rdata | output | DATA_W | Read word (zero unless a read got OK) |
| rsp_par_err | output | 1 | Read parity mismatch |
| rsp_proto_err | output | 1 | Acknowledge was not a legal code |

## Verification
Two things can land on the same system clock: the end of a packet and the acceptance of the next command. In the completion cycle the engine both raises the response pulse and reports itself free. The bench provokes this by holding `cmd_valid` high across the end of a read. It then checks that the response fields carry the first packet's values, that `cmd_ready` drops on the very next edge, and that the second packet's request appears on the wire with the correct slot count. A model of the target in the bench drives acknowledge and read data by counting clock rises, and it records every host-driven slot so that request, data, parity, turnaround and padding can be judged slot by slot.

// File: rtl/swdm_pkg.sv
package swdm_pkg;

   localparam logic [2:0] ACK_OK    = 3'b001;
   localparam logic [2:0] ACK_WAIT  = 3'b010;
   localparam logic [2:0] ACK_FAULT = 3'b100;

   localparam int REQ_BITS = 8;
   localparam int ACK_BITS = 3;

   typedef enum logic [3:0] {
      S_IDLE,
      S_REQ,
      S_TRN_A,
      S_ACK,
      S_TRN_W,
      S_WDAT,
      S_WPAR,
      S_RDAT,
      S_RPAR,
      S_TRN_E,
      S_PAD
   } swdm_state_e;

endpackage

// File: rtl/swdm_tick.sv
module swdm_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   a_r3_tick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= half || $past(half) != half));

endmodule

// File: rtl/swdm_frame.sv
module swdm_frame #(
   parameter int DATA_W = 32
) (
   input  logic              ap,
   input  logic              rnw,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] rdata,
   output logic [7:0]        req_bits,
   output logic              wpar,
   output logic              rpar
);

   logic hdr_par;

   assign hdr_par  = ap ^ rnw ^ addr[0] ^ addr[1];
   // slot i of the request is req_bits[i]
   assign req_bits = {1'b1, 1'b0, hdr_par, addr[1], addr[0], rnw, ap, 1'b1};
   assign wpar     = ^wdata;
   assign rpar     = ^rdata;

endmodule

// File: rtl/swdm_seq.sv
module swdm_seq
   import swdm_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int IDLE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cmd_valid,
   input  logic              cmd_ap,
   input  logic              cmd_rnw,
   input  logic [1:0]        cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [7:0]        req_bits,
   input  logic              wpar,
   input  logic              rpar,
   output logic              lat_ap,
   output logic              lat_rnw,
   output logic [1:0]        lat_addr,
   output logic [DATA_W-1:0] lat_wdata,
   output logic [DATA_W-1:0] rdat_q,
   output logic              busy,
   output logic              swclk,
   output logic              swdio_o,
   output logic              swdio_oe,
   input  logic              swdio_i,
   output logic              rsp_valid,
   output logic [2:0]        rsp_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_par_err,
   output logic              rsp_proto_err
);

   localparam int MAXC     = (DATA_W > IDLE_CYC) ? DATA_W : IDLE_CYC;
   localparam int CNT_W    = $clog2(MAXC) + 1;
   localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int PAD_LAST = (IDLE_CYC > 0) ? IDLE_CYC - 1 : 0;
   localparam bit NO_PAD   = (IDLE_CYC == 0);

   swdm_state_e      st;
   logic [CNT_W-1:0] bcnt;
   logic [2:0]       ack_q;
   logic             rpar_q;
   logic             ok_q;
   logic             bad_q;
   logic             rise;
   logic             fall;
   logic             fin;

   assign busy = (st != S_IDLE);
   assign rise = tick && !swclk;
   assign fall = tick && swclk;

   always_comb begin
      fin = 1'b0;
      if (fall) begin
         case (st)
            S_WPAR:  fin = NO_PAD;
            S_TRN_E: fin = bad_q || NO_PAD;
            S_PAD:   fin = (bcnt == CNT_W'(PAD_LAST));
            default: fin = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         bcnt      <= '0;
         swclk     <= 1'b0;
         swdio_o   <= 1'b0;
         swdio_oe  <= 1'b0;
         ack_q     <= '0;
         rpar_q    <= 1'b0;
         ok_q      <= 1'b0;
         bad_q     <= 1'b0;
         rdat_q    <= '0;
         lat_ap    <= 1'b0;
         lat_rnw   <= 1'b0;
         lat_addr  <= '0;
         lat_wdata <= '0;
      end else if (st == S_IDLE) begin
         if (cmd_valid) begin
            lat_ap    <= cmd_ap;
            lat_rnw   <= cmd_rnw;
            lat_addr  <= cmd_addr;
            lat_wdata <= cmd_wdata;
            ok_q      <= 1'b0;
            bad_q     <= 1'b0;
            bcnt      <= '0;
            st        <= S_REQ;
            swdio_o   <= 1'b1;
            swdio_oe  <= 1'b1;
         end
      end else if (rise) begin
         swclk <= 1'b1;
         case (st)
            S_ACK:   ack_q[bcnt[1:0]]     <= swdio_i;
            S_RDAT:  rdat_q[bcnt[IDX_W-1:0]] <= swdio_i;
            S_RPAR:  rpar_q               <= swdio_i;
            default: ;
         endcase
      end else if (fall) begin
         swclk <= 1'b0;
         if (fin) begin
            st       <= S_IDLE;
            swdio_o  <= 1'b0;
            swdio_oe <= 1'b0;
         end else begin
            case (st)
               S_REQ: begin
                  if (bcnt == CNT_W'(REQ_BITS - 1)) begin
                     st       <= S_TRN_A;
                     swdio_oe <= 1'b0;
                  end else begin
                     bcnt    <= bcnt + 1'b1;
                     swdio_o <= req_bits[bcnt[2:0] + 3'd1];
                  end
               end
               S_TRN_A: begin
                  st   <= S_ACK;
                  bcnt <= '0;
               end
               S_ACK: begin
                  if (bcnt != CNT_W'(ACK_BITS - 1)) begin
                     bcnt <= bcnt + 1'b1;
                  end else begin
                     bcnt <= '0;
                     case (ack_q)
                        ACK_OK: begin
                           ok_q <= 1'b1;
                           st   <= lat_rnw ? S_RDAT : S_TRN_W;
                        end
                        ACK_WAIT, ACK_FAULT: st <= S_TRN_E;
                        default: begin
                           bad_q <= 1'b1;
                           st    <= S_TRN_E;
                        end
                     endcase
                  end
               end
               S_TRN_W: begin
                  st       <= S_WDAT;
                  bcnt     <= '0;
                  swdio_oe <= 1'b1;
                  swdio_o  <= lat_wdata[0];
               end
               S_WDAT: begin
                  if (bcnt == CNT_W'(DATA_W - 1)) begin
                     st      <= S_WPAR;
                     swdio_o <= wpar;
                  end else begin
                     bcnt    <= bcnt + 1'b1;
                     swdio_o <= lat_wdata[bcnt[IDX_W-1:0] + 1'b1];
                  end
               end
               S_RDAT: begin
                  if (bcnt == CNT_W'(DATA_W - 1)) begin
                     st <= S_RPAR;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               S_RPAR: st <= S_TRN_E;
               S_WPAR, S_TRN_E: begin
                  st       <= S_PAD;
                  bcnt     <= '0;
                  swdio_o  <= 1'b0;
                  swdio_oe <= 1'b1;
               end
               S_PAD:   bcnt <= bcnt + 1'b1;
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_ack       <= '0;
         rsp_rdata     <= '0;
         rsp_par_err   <= 1'b0;
         rsp_proto_err <= 1'b0;
      end else begin
         rsp_valid <= fin;
         if (fin) begin
            rsp_ack       <= ack_q;
            rsp_rdata     <= (ok_q && lat_rnw) ? rdat_q : '0;
            rsp_par_err   <= ok_q && lat_rnw && (rpar != rpar_q);
            rsp_proto_err <= bad_q;
         end
      end
   end

   a_r10_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (swclk && $past(swclk)) |-> ($stable(swdio_o) && $stable(swdio_oe)));

   a_r3_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> !swclk);

   a_r4_released_around_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_TRN_A || st == S_ACK || st == S_TRN_W || st == S_RDAT) |-> !swdio_oe);

   a_r7_data_only_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WDAT || st == S_RDAT || st == S_WPAR || st == S_RPAR) |-> ok_q);

   a_r8_release_on_bad_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_proto_err) |-> (!swdio_oe && !rsp_par_err));

   a_r6_par_err_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_par_err) |-> (rsp_ack == ACK_OK));

   a_r11_free_at_response: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (st == S_IDLE || $past(st) == S_IDLE));

endmodule

// File: rtl/swdm_master.sv
module swdm_master #(
   parameter int DATA_W   = 32,
   parameter int DIV_W    = 8,
   parameter int IDLE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_half,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_ap,
   input  logic              cmd_rnw,
   input  logic [1:0]        cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              swclk,
   output logic              swdio_o,
   output logic              swdio_oe,
   input  logic              swdio_i,
   output logic              rsp_valid,
   output logic [2:0]        rsp_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_par_err,
   output logic              rsp_proto_err
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("swdm_master: DATA_W must be at least 2");
      end
      if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div_w
         $error("swdm_master: DIV_W out of range");
      end
      if (IDLE_CYC < 0 || IDLE_CYC > 64) begin : g_bad_idle
         $error("swdm_master: IDLE_CYC out of range");
      end
   endgenerate

   logic              tick;
   logic              busy;
   logic              lat_ap;
   logic              lat_rnw;
   logic [1:0]        lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic [DATA_W-1:0] rdat_q;
   logic [7:0]        req_bits;
   logic              wpar;
   logic              rpar;

   assign cmd_ready = !busy;

   swdm_tick #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .half  (cfg_half),
      .tick  (tick)
   );

   swdm_frame #(.DATA_W(DATA_W)) u_frame (
      .ap       (lat_ap),
      .rnw      (lat_rnw),
      .addr     (lat_addr),
      .wdata    (lat_wdata),
      .rdata    (rdat_q),
      .req_bits (req_bits),
      .wpar     (wpar),
      .rpar     (rpar)
   );

   swdm_seq #(.DATA_W(DATA_W), .IDLE_CYC(IDLE_CYC)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .cmd_valid     (cmd_valid),
      .cmd_ap        (cmd_ap),
      .cmd_rnw       (cmd_rnw),
      .cmd_addr      (cmd_addr),
      .cmd_wdata     (cmd_wdata),
      .req_bits      (req_bits),
      .wpar          (wpar),
      .rpar          (rpar),
      .lat_ap        (lat_ap),
      .lat_rnw       (lat_rnw),
      .lat_addr      (lat_addr),
      .lat_wdata     (lat_wdata),
      .rdat_q        (rdat_q),
      .busy          (busy),
      .swclk         (swclk),
      .swdio_o       (swdio_o),
      .swdio_oe      (swdio_oe),
      .swdio_i       (swdio_i),
      .rsp_valid     (rsp_valid),
      .rsp_ack       (rsp_ack),
      .rsp_rdata     (rsp_rdata),
      .rsp_par_err   (rsp_par_err),
      .rsp_proto_err (rsp_proto_err)
   );

   a_r1_ready_tracks_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && !cmd_valid) |=> cmd_ready);

endmodule

// File: tb/swdm_master_tb.sv
module swdm_master_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_half = 8'd1;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_ap = 1'b0;
   logic        cmd_rnw = 1'b0;
   logic [1:0]  cmd_addr = 2'b00;
   logic [31:0] cmd_wdata = '0;
   logic        swclk;
   logic        swdio_o;
   logic        swdio_oe;
   logic        swdio_i;
   logic        rsp_valid;
   logic [2:0]  rsp_ack;
   logic [31:0] rsp_rdata;
   logic        rsp_par_err;
   logic        rsp_proto_err;

   always #10 clk = ~clk;

   swdm_master u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ap(cmd_ap),
      .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
      .rsp_par_err(rsp_par_err), .rsp_proto_err(rsp_proto_err)
   );

   int n_chk = 0;
   int n_fail = 0;

   // target model state
   int          rise_cnt = 0;
   logic [2:0]  tgt_ack = 3'b001;
   logic        tgt_rnw = 1'b0;
   logic [31:0] tgt_rdata = '0;
   logic        tgt_flip = 1'b0;
   logic        h_bit [0:63];
   logic        h_oe  [0:63];
   time         t_rise [0:63];
   logic        last_o = 1'b0;
   logic        last_oe = 1'b0;
   int          hold_viol = 0;

   always @(posedge swclk) begin
      if (rise_cnt < 64) begin
         h_bit[rise_cnt]  = swdio_o;
         h_oe[rise_cnt]   = swdio_oe;
         t_rise[rise_cnt] = $time;
      end
      last_o  = swdio_o;
      last_oe = swdio_oe;
      #1 rise_cnt = rise_cnt + 1;
   end

   always @(negedge clk) begin
      if (swclk && (swdio_o !== last_o || swdio_oe !== last_oe))
         hold_viol = hold_viol + 1;
   end

   always_comb begin
      swdio_i = 1'b1;
      if (rise_cnt >= 9 && rise_cnt <= 11)
         swdio_i = tgt_ack[rise_cnt-9];
      else if (tgt_rnw && tgt_ack == 3'b001 && rise_cnt >= 12 && rise_cnt <= 43)
         swdio_i = tgt_rdata[rise_cnt-12];
      else if (tgt_rnw && tgt_ack == 3'b001 && rise_cnt == 44)
         swdio_i = (^tgt_rdata) ^ tgt_flip;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_req(input logic ap, input logic rnw,
                                          input logic [1:0] a);
      exp_req = {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
   endfunction

   function automatic logic [7:0] got_req();
      logic [7:0] v;
      for (int i = 0; i < 8; i++) v[i] = h_bit[i];
      return v;
   endfunction

   task automatic wait_rsp();
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (rsp_valid) return;
      end
      chk(1'b0, "response timeout", 0, 1);
   endtask

   task automatic run_cmd(input logic ap, input logic rnw, input logic [1:0] a,
                          input logic [31:0] wd);
      @(negedge clk);
      rise_cnt  = 0;
      cmd_ap    = ap;
      cmd_rnw   = rnw;
      cmd_addr  = a;
      cmd_wdata = wd;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_rsp();
   endtask

   task automatic t_reset();
      chk(swclk == 1'b0 && swdio_oe == 1'b0, "R1 line idle after reset",
          {swclk, swdio_oe}, 0);
      chk(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R1 ready, no response",
          {cmd_ready, rsp_valid}, 2);
   endtask

   task automatic t_write_ok();
      logic [31:0] wd = 32'hA5C3_0F17;
      logic ok;
      tgt_ack = 3'b001; tgt_rnw = 1'b0;
      run_cmd(1'b1, 1'b0, 2'b01, wd);
      chk(got_req() == exp_req(1'b1, 1'b0, 2'b01), "R2 write request bits",
          got_req(), exp_req(1'b1, 1'b0, 2'b01));
      ok = 1'b1;
      for (int i = 8; i <= 12; i++) if (h_oe[i] !== 1'b0) ok = 1'b0;
      chk(ok, "R4 released for turnaround/ack/turnaround", 0, 0);
      ok = 1'b1;
      for (int i = 0; i < 32; i++)
         if (h_oe[13+i] !== 1'b1 || h_bit[13+i] !== wd[i]) ok = 1'b0;
      chk(ok, "R5 write data LSB first", 0, wd);
      chk(h_bit[45] == ^wd && h_oe[45], "R5 write parity", h_bit[45], ^wd);
      ok = 1'b1;
      for (int i = 46; i <= 53; i++) if (h_oe[i] !== 1'b1 || h_bit[i] !== 1'b0) ok = 1'b0;
      chk(ok, "R9 eight zero idle slots", 0, 0);
      chk(rise_cnt == 54, "R9 write packet length", rise_cnt, 54);
      chk(rsp_ack == 3'b001 && !rsp_proto_err && !rsp_par_err, "R5 write ack OK",
          rsp_ack, 1);
   endtask

   task automatic t_read_ok(input logic [31:0] rd, input logic flip);
      logic ok;
      tgt_ack = 3'b001; tgt_rnw = 1'b1; tgt_rdata = rd; tgt_flip = flip;
      run_cmd(1'b0, 1'b1, 2'b11, 32'h0);
      chk(got_req() == exp_req(1'b0, 1'b1, 2'b11), "R2 read request bits",
          got_req(), exp_req(1'b0, 1'b1, 2'b11));
      chk(rsp_rdata == rd, "R6 read data", rsp_rdata, rd);
      chk(rsp_par_err == flip, "R6 read parity flag", rsp_par_err, flip);
      ok = 1'b1;
      for (int i = 8; i <= 45; i++) if (h_oe[i] !== 1'b0) ok = 1'b0;
      chk(ok, "R6 line released through data, parity, turnaround", 0, 0);
      chk(rise_cnt == 54 && h_oe[46] && h_oe[53], "R9 read packet length",
          rise_cnt, 54);
      tgt_flip = 1'b0;
   endtask

   task automatic t_stall(input logic [2:0] code);
      logic ok;
      tgt_ack = code; tgt_rnw = 1'b0;
      run_cmd(1'b1, 1'b0, 2'b10, 32'hFFFF_FFFF);
      chk(rsp_ack == code && !rsp_proto_err, "R7 stall code reported", rsp_ack, code);
      chk(rise_cnt == 21, "R7 no data phase", rise_cnt, 21);
      ok = (h_oe[12] === 1'b0);
      for (int i = 13; i <= 20; i++) if (h_oe[i] !== 1'b1 || h_bit[i] !== 1'b0) ok = 1'b0;
      chk(ok, "R7 turnaround then idle zeros", 0, 0);
      chk(rsp_rdata == 32'h0, "R7 no read data", rsp_rdata, 0);
   endtask

   task automatic t_bad_ack();
      tgt_ack = 3'b111; tgt_rnw = 1'b1; tgt_rdata = 32'h1234_5678;
      run_cmd(1'b0, 1'b1, 2'b00, 32'h0);
      chk(rsp_proto_err && rsp_ack == 3'b111, "R8 protocol error flagged",
          {rsp_proto_err, rsp_ack}, 4'hF);
      chk(rise_cnt == 13, "R8 no padding", rise_cnt, 13);
      chk(swdio_oe == 1'b0, "R8 line released", swdio_oe, 0);
   endtask

   task automatic t_divider();
      int r0;
      cfg_half = 8'd3;
      tgt_ack = 3'b010; tgt_rnw = 1'b0;
      run_cmd(1'b0, 1'b0, 2'b00, 32'h0);
      chk(t_rise[2] - t_rise[1] == 160, "R3 clock period with half=3",
          t_rise[2] - t_rise[1], 160);
      r0 = rise_cnt;
      repeat (20) @(negedge clk);
      chk(swclk == 1'b0 && rise_cnt == r0, "R3 clock low when idle", rise_cnt, r0);
      cfg_half = 8'd1;
   endtask

   task automatic t_back_to_back();
      logic [31:0] rd = 32'h8000_0001;
      tgt_ack = 3'b001; tgt_rnw = 1'b1; tgt_rdata = rd;
      @(negedge clk);
      rise_cnt = 0;
      cmd_ap = 1'b1; cmd_rnw = 1'b1; cmd_addr = 2'b10; cmd_wdata = '0;
      cmd_valid = 1'b1;
      @(negedge clk);
      wait_rsp();
      // completion cycle: command still presented
      chk(cmd_ready == 1'b1, "R11 ready in completion cycle", cmd_ready, 1);
      chk(rsp_rdata == rd, "R11 first response data", rsp_rdata, rd);
      rise_cnt = 0;
      tgt_ack = 3'b100; tgt_rnw = 1'b0;
      cmd_ap = 1'b0; cmd_rnw = 1'b0; cmd_addr = 2'b01;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cmd_ready == 1'b0, "R11 second command taken at once", cmd_ready, 0);
      chk(rsp_rdata == rd && rsp_ack == 3'b001, "R11 response held", rsp_rdata, rd);
      wait_rsp();
      chk(got_req() == exp_req(1'b0, 1'b0, 2'b01) && rise_cnt == 21,
          "R11 second packet on wire", got_req(), exp_req(1'b0, 1'b0, 2'b01));
      chk(rsp_ack == 3'b100, "R7 fault code", rsp_ack, 3'b100);
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_write_ok();
      t_read_ok(32'h0F0F_1234, 1'b0);
      t_read_ok(32'h7777_0001, 1'b1);
      t_stall(3'b010);
      t_stall(3'b100);
      t_bad_ack();
      t_divider();
      t_back_to_back();
      chk(hold_viol == 0, "R10 outputs steady while clock high", hold_viol, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule